// File: doc/BRIEF.md
# Byte-Packed Variable-Width Register File

This block is a register file of 64-bit registers whose contents are held as one flat, little-endian byte store. Each access names a base register, an element index and an element width of 8, 16, 32 or 64 bits. The element's byte address is the base register's first byte plus the index times the element size. An element therefore lands in a later register whenever the index runs past the end of the base register. Any access may use any width, so one instruction can view storage as bytes that the next one reads as words.

There are two combinational read ports and one write port. The write port updates only the bytes that belong to the addressed element, using a byte-enable built from the width and the byte lane. An access whose element would run past the last byte of the store is flagged. A flagged read returns zero and a flagged write is dropped. Decoding of widths and indices, and all arithmetic, is done by the logic that drives the ports.

Top module: `elem_regfile`

## Requirements
- R1: A synchronous active-high reset clears every byte of the store, so every in-range read returns zero after it.
- R2: The element byte address is base × 8 + index × size, where size is the element width in bytes. The containing register is that address divided by 8, so elements spill into the registers that follow the base.
- R3: Storage is little-endian: byte k of an element sits at its byte address plus k. After the single byte 0x01 is written to byte 3 of a cleared register, the 16-bit element 1 reads 0x0100, the 32-bit element 0 reads 0x01000000, and the 64-bit element 0 reads 0x0000000001000000.
- R4: The width code is 0 for 8 bits, 1 for 16, 2 for 32 and 3 for 64. The code may change from access to access on the same storage. Read data is the element zero-extended to 64 bits.
- R5: A write changes only the bytes of the addressed element. Data bits above the element width are ignored, and all other bytes keep their values.
- R6: An access whose last byte lies past byte 1023 (register 127, byte 7) raises its port's error output. Such a read returns zero, and such a write leaves the store unchanged.
- R7: Reads are combinational. A write takes effect at the rising clock edge, so a read of the same element in the write's cycle returns the old value, and the new value is visible after the edge.
- R8: The two read ports address the store independently and may read different elements, of different widths, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, clears the store |
| ra_base | input | 7 | Read port A base register |
| ra_idx | input | 10 | Read port A element index |
| ra_wid | input | 2 | Read port A width code |
| ra_data | output | 64 | Read port A element, zero-extended |
| ra_err | output | 1 | Read port A access out of range |
| rb_base | input | 7 | Read port B base register |
| rb_idx | input | 10 | Read port B element index |
| rb_wid | input | 2 | Read port B width code |
| rb_data | output | 64 | Read port B element, zero-extended |
| rb_err | output | 1 | Read port B access out of range |
| wr_en | input | 1 | Write request |
| wr_base | input | 7 | Write base register |
| wr_idx | input | 10 | Write element index |
| wr_wid | input | 2 | Write width code |
| wr_data | input | 64 | Write element, low bits used |
| wr_err | output | 1 | Write access out of range, write dropped |

## Verification
A write and a combinational read can hit the same bytes in the same cycle. The bench provokes this by holding a 64-bit write to a register while port A reads that register and port B reads a 16-bit slice of it. It first checks that both ports return the old contents before the edge. After the edge it checks that they return the new bytes. Narrow writes into registers that already hold data are then read back at full width, which checks that the neighbouring bytes are untouched.

// File: rtl/elem_rf_pkg.sv
package elem_rf_pkg;
  // width code carried on every port
  localparam int WID_W = 2;

  typedef enum logic [WID_W-1:0] {
    EW_B8  = 2'd0,
    EW_B16 = 2'd1,
    EW_B32 = 2'd2,
    EW_B64 = 2'd3
  } ew_e;

  // element size in bytes for a width code
  function automatic int unsigned ew_bytes(input ew_e w);
    return 32'd1 << w;
  endfunction
endpackage

// File: rtl/elem_addr_gen.sv
module elem_addr_gen
  import elem_rf_pkg::*;
#(
  parameter int NUM_REGS  = 128,
  parameter int REG_BYTES = 8,
  parameter int IDX_W     = 10
) (
  input  logic [$clog2(NUM_REGS)-1:0]  base,
  input  logic [IDX_W-1:0]             idx,
  input  logic [WID_W-1:0]             wid,
  output logic [$clog2(NUM_REGS)-1:0]  row,
  output logic [$clog2(REG_BYTES)-1:0] lane,
  output logic                         oob
);
  localparam int RIDX_W = $clog2(NUM_REGS);
  localparam int LANE_W = $clog2(REG_BYTES);
  localparam int ADDR_W = RIDX_W + LANE_W + IDX_W;
  localparam int ROWF_W = ADDR_W - LANE_W;

  logic [ADDR_W-1:0] base_off;
  logic [ADDR_W-1:0] idx_off;
  logic [ADDR_W-1:0] byte_addr;
  logic [ROWF_W-1:0] row_full;

  always_comb begin
    base_off  = ADDR_W'(base) << LANE_W;
    idx_off   = ADDR_W'(idx) << wid;
    byte_addr = base_off + idx_off;
    row_full  = byte_addr[ADDR_W-1:LANE_W];
    // elements are naturally aligned, so an element never straddles a row:
    // it is out of range exactly when its row does not exist
    oob  = row_full >= ROWF_W'(NUM_REGS);
    row  = row_full[RIDX_W-1:0];
    lane = byte_addr[LANE_W-1:0];
  end
endmodule

// File: rtl/elem_read_align.sv
module elem_read_align
  import elem_rf_pkg::*;
#(
  parameter int REG_BYTES = 8
) (
  input  logic [REG_BYTES*8-1:0]       row_word,
  input  logic [$clog2(REG_BYTES)-1:0] lane,
  input  logic [WID_W-1:0]             wid,
  input  logic                         oob,
  output logic [REG_BYTES*8-1:0]       data
);
  localparam int DATA_W = REG_BYTES * 8;
  localparam int LANE_W = $clog2(REG_BYTES);

  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] keep;

  always_comb begin
    shifted = row_word >> {lane, 3'b000};
    for (int b = 0; b < REG_BYTES; b++) begin
      keep[8*b +: 8] = (b < int'(ew_bytes(ew_e'(wid)))) ? 8'hFF : 8'h00;
    end
    data = oob ? '0 : (shifted & keep);
  end
endmodule

// File: rtl/elem_write_align.sv
module elem_write_align
  import elem_rf_pkg::*;
#(
  parameter int REG_BYTES = 8
) (
  input  logic [$clog2(REG_BYTES)-1:0] lane,
  input  logic [WID_W-1:0]             wid,
  input  logic [REG_BYTES*8-1:0]       wdata,
  output logic [REG_BYTES*8-1:0]       lane_data,
  output logic [REG_BYTES-1:0]         be
);
  localparam int DATA_W = REG_BYTES * 8;

  logic [REG_BYTES-1:0] be_raw;

  always_comb begin
    for (int b = 0; b < REG_BYTES; b++) begin
      be_raw[b] = (b < int'(ew_bytes(ew_e'(wid))));
    end
    be        = be_raw << lane;
    lane_data = wdata << {lane, 3'b000};
  end
endmodule

// File: rtl/elem_regfile.sv
module elem_regfile
  import elem_rf_pkg::*;
#(
  parameter int NUM_REGS  = 128,
  parameter int REG_BYTES = 8,
  parameter int IDX_W     = 10
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [$clog2(NUM_REGS)-1:0] ra_base,
  input  logic [IDX_W-1:0]            ra_idx,
  input  logic [WID_W-1:0]            ra_wid,
  output logic [REG_BYTES*8-1:0]      ra_data,
  output logic                        ra_err,
  input  logic [$clog2(NUM_REGS)-1:0] rb_base,
  input  logic [IDX_W-1:0]            rb_idx,
  input  logic [WID_W-1:0]            rb_wid,
  output logic [REG_BYTES*8-1:0]      rb_data,
  output logic                        rb_err,
  input  logic                        wr_en,
  input  logic [$clog2(NUM_REGS)-1:0] wr_base,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [WID_W-1:0]            wr_wid,
  input  logic [REG_BYTES*8-1:0]      wr_data,
  output logic                        wr_err
);
  localparam int DATA_W = REG_BYTES * 8;
  localparam int RIDX_W = $clog2(NUM_REGS);
  localparam int LANE_W = $clog2(REG_BYTES);

  // byte store, one row per register, byte lanes little-endian
  logic [DATA_W-1:0] mem_q [NUM_REGS];

  logic [RIDX_W-1:0] ra_row, rb_row, wr_row;
  logic [LANE_W-1:0] ra_lane, rb_lane, wr_lane;
  logic [DATA_W-1:0] wr_lane_data;
  logic [REG_BYTES-1:0] wr_be;
  logic wr_go;

  elem_addr_gen #(.NUM_REGS(NUM_REGS), .REG_BYTES(REG_BYTES), .IDX_W(IDX_W)) u_agen_a (
    .base(ra_base), .idx(ra_idx), .wid(ra_wid),
    .row(ra_row), .lane(ra_lane), .oob(ra_err));

  elem_addr_gen #(.NUM_REGS(NUM_REGS), .REG_BYTES(REG_BYTES), .IDX_W(IDX_W)) u_agen_b (
    .base(rb_base), .idx(rb_idx), .wid(rb_wid),
    .row(rb_row), .lane(rb_lane), .oob(rb_err));

  elem_addr_gen #(.NUM_REGS(NUM_REGS), .REG_BYTES(REG_BYTES), .IDX_W(IDX_W)) u_agen_w (
    .base(wr_base), .idx(wr_idx), .wid(wr_wid),
    .row(wr_row), .lane(wr_lane), .oob(wr_err));

  elem_read_align #(.REG_BYTES(REG_BYTES)) u_ralign_a (
    .row_word(mem_q[ra_row]), .lane(ra_lane), .wid(ra_wid),
    .oob(ra_err), .data(ra_data));

  elem_read_align #(.REG_BYTES(REG_BYTES)) u_ralign_b (
    .row_word(mem_q[rb_row]), .lane(rb_lane), .wid(rb_wid),
    .oob(rb_err), .data(rb_data));

  elem_write_align #(.REG_BYTES(REG_BYTES)) u_walign (
    .lane(wr_lane), .wid(wr_wid), .wdata(wr_data),
    .lane_data(wr_lane_data), .be(wr_be));

  assign wr_go = wr_en && !wr_err;

  // byte-enabled row write; reset clears every row
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NUM_REGS; r++) mem_q[r] <= '0;
    end else if (wr_go) begin
      for (int b = 0; b < REG_BYTES; b++) begin
        if (wr_be[b]) mem_q[wr_row][8*b +: 8] <= wr_lane_data[8*b +: 8];
      end
    end
  end

  // ---------------- checks next to the store ----------------
  logic              chk_valid;
  logic [RIDX_W-1:0] chk_row;
  logic [DATA_W-1:0] chk_old, chk_new, chk_mask;
  logic [DATA_W-1:0] ra_width_mask, rb_width_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_valid <= 1'b0;
      chk_row   <= '0;
      chk_old   <= '0;
      chk_new   <= '0;
      chk_mask  <= '0;
    end else begin
      chk_valid <= wr_go;
      chk_row   <= wr_row;
      chk_old   <= mem_q[wr_row];
      chk_new   <= wr_lane_data;
      for (int b = 0; b < REG_BYTES; b++) chk_mask[8*b +: 8] <= {8{wr_be[b]}};
    end
  end

  always_comb begin
    ra_width_mask = (ra_wid == EW_B64) ? '1 : ((DATA_W'(1) << (8 << ra_wid)) - DATA_W'(1));
    rb_width_mask = (rb_wid == EW_B64) ? '1 : ((DATA_W'(1) << (8 << rb_wid)) - DATA_W'(1));
  end

  // R5: bytes outside the element keep their value across a write
  a_r5_neighbours_kept: assert property (@(posedge clk) disable iff (rst)
    chk_valid |-> (((mem_q[chk_row] ^ chk_old) & ~chk_mask) == '0));

  // R7: the element bytes hold the written data after the edge
  a_r7_write_lands: assert property (@(posedge clk) disable iff (rst)
    chk_valid |-> ((mem_q[chk_row] & chk_mask) == (chk_new & chk_mask)));

  // R4: read data is zero above the element width
  a_r4_zero_ext_a: assert property (@(posedge clk) disable iff (rst)
    (ra_data & ~ra_width_mask) == '0);
  a_r4_zero_ext_b: assert property (@(posedge clk) disable iff (rst)
    (rb_data & ~rb_width_mask) == '0);

  // R6: an out-of-range read returns zero
  a_r6_oob_read_zero: assert property (@(posedge clk) disable iff (rst)
    (ra_err |-> ra_data == '0) and (rb_err |-> rb_data == '0));
endmodule

// File: tb/elem_regfile_tb.sv
module elem_regfile_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [6:0]  ra_base, rb_base, wr_base;
  logic [9:0]  ra_idx, rb_idx, wr_idx;
  logic [1:0]  ra_wid, rb_wid, wr_wid;
  logic [63:0] ra_data, rb_data, wr_data;
  logic        ra_err, rb_err, wr_err, wr_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  elem_regfile u_dut (
    .clk(clk), .rst(rst),
    .ra_base(ra_base), .ra_idx(ra_idx), .ra_wid(ra_wid), .ra_data(ra_data), .ra_err(ra_err),
    .rb_base(rb_base), .rb_idx(rb_idx), .rb_wid(rb_wid), .rb_data(rb_data), .rb_err(rb_err),
    .wr_en(wr_en), .wr_base(wr_base), .wr_idx(wr_idx), .wr_wid(wr_wid),
    .wr_data(wr_data), .wr_err(wr_err));

  typedef struct packed {
    logic        wr;
    logic [6:0]  base;
    logic [9:0]  idx;
    logic [1:0]  wid;
    logic [63:0] data;  // write data, or expected read data
    logic        err;   // expected error flag
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 7'd5,   10'd3, 2'd0, 64'h01,                 1'b0}, // R3 byte 3 of reg5
    '{1'b0, 7'd5,   10'd1, 2'd1, 64'h0100,               1'b0}, // R3 16-bit elem 1
    '{1'b0, 7'd5,   10'd0, 2'd2, 64'h01000000,           1'b0}, // R3 32-bit elem 0
    '{1'b0, 7'd5,   10'd0, 2'd3, 64'h01000000,           1'b0}, // R3 64-bit elem 0
    '{1'b1, 7'd2,   10'd5, 2'd1, 64'hBEEF,               1'b0}, // R2 byte 10 -> reg3
    '{1'b0, 7'd3,   10'd0, 2'd3, 64'h00000000BEEF0000,   1'b0}, // R2 spill seen in reg3
    '{1'b0, 7'd3,   10'd1, 2'd1, 64'hBEEF,               1'b0}, // R2
    '{1'b0, 7'd2,   10'd5, 2'd1, 64'hBEEF,               1'b0}, // R2
    '{1'b1, 7'd10,  10'd0, 2'd3, 64'h8877665544332211,   1'b0}, // R4 full width
    '{1'b1, 7'd10,  10'd1, 2'd0, 64'hFFFFFFFFFFFFFFAA,   1'b0}, // R5 upper bits ignored
    '{1'b0, 7'd10,  10'd0, 2'd3, 64'h887766554433AA11,   1'b0}, // R5
    '{1'b1, 7'd10,  10'd1, 2'd2, 64'h00000000DEADBEEF,   1'b0}, // R5 upper half
    '{1'b0, 7'd10,  10'd0, 2'd3, 64'hDEADBEEF4433AA11,   1'b0}, // R5
    '{1'b0, 7'd10,  10'd3, 2'd1, 64'hDEAD,               1'b0}, // R4 width change
    '{1'b0, 7'd9,   10'd1, 2'd3, 64'hDEADBEEF4433AA11,   1'b0}, // R2 64-bit spill
    '{1'b1, 7'd4,   10'd3, 2'd2, 64'hCAFEF00D,           1'b0}, // R2 32-bit spill
    '{1'b0, 7'd5,   10'd0, 2'd3, 64'hCAFEF00D01000000,   1'b0}, // R2 R5
    '{1'b0, 7'd5,   10'd3, 2'd0, 64'h01,                 1'b0}, // R4 byte read
    '{1'b1, 7'd120, 10'd7, 2'd3, 64'h0123456789ABCDEF,   1'b0}, // R6 last register ok
    '{1'b0, 7'd127, 10'd0, 2'd3, 64'h0123456789ABCDEF,   1'b0}, // R6
    '{1'b0, 7'd127, 10'd1, 2'd0, 64'hCD,                 1'b0}, // R3
    '{1'b0, 7'd127, 10'd3, 2'd1, 64'h0123,               1'b0}, // R6 bytes 1022..1023
    '{1'b1, 7'd120, 10'd8, 2'd3, 64'hFFFFFFFFFFFFFFFF,   1'b1}, // R6 write dropped
    '{1'b0, 7'd127, 10'd0, 2'd3, 64'h0123456789ABCDEF,   1'b0}, // R6 store unchanged
    '{1'b0, 7'd127, 10'd4, 2'd1, 64'h0,                  1'b1}, // R6 past byte 1023
    '{1'b0, 7'd126, 10'd2, 2'd3, 64'h0,                  1'b1}  // R6 past end
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_a(input logic [6:0] b, input logic [9:0] i, input logic [1:0] w);
    ra_base = b; ra_idx = i; ra_wid = w;
  endtask

  task automatic set_b(input logic [6:0] b, input logic [9:0] i, input logic [1:0] w);
    rb_base = b; rb_idx = i; rb_wid = w;
  endtask

  initial begin
    rst = 1'b1; wr_en = 1'b0;
    set_a(7'd0, 10'd0, 2'd3); set_b(7'd0, 10'd0, 2'd3);
    wr_base = '0; wr_idx = '0; wr_wid = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: store is clear after reset
    @(negedge clk);
    set_a(7'd0, 10'd0, 2'd3); set_b(7'd127, 10'd0, 2'd3);
    #1 check("R1 reg0 after reset", ra_data, 64'h0);
    check("R1 reg127 after reset", rb_data, 64'h0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      if (VEC[v].wr) begin
        wr_en = 1'b1; wr_base = VEC[v].base; wr_idx = VEC[v].idx;
        wr_wid = VEC[v].wid; wr_data = VEC[v].data;
        #1 check($sformatf("R6 write err row %0d", v), 64'(wr_err), 64'(VEC[v].err));
        @(posedge clk);
        #1 wr_en = 1'b0;
      end else begin
        set_a(VEC[v].base, VEC[v].idx, VEC[v].wid);
        #1 check($sformatf("R2 R3 read data row %0d", v), ra_data, VEC[v].data);
        check($sformatf("R6 read err row %0d", v), 64'(ra_err), 64'(VEC[v].err));
      end
    end

    // R8: two ports, different elements and widths, same cycle
    @(negedge clk);
    set_a(7'd10, 10'd0, 2'd3); set_b(7'd3, 10'd1, 2'd1);
    #1 check("R8 port A", ra_data, 64'hDEADBEEF4433AA11);
    check("R8 port B", rb_data, 64'hBEEF);

    // R7: read of the element being written sees old data, then new
    @(negedge clk);
    wr_en = 1'b1; wr_base = 7'd20; wr_idx = 10'd0; wr_wid = 2'd3;
    wr_data = 64'h55AA33CC0F0F1234;
    set_a(7'd20, 10'd0, 2'd3); set_b(7'd20, 10'd2, 2'd1);
    #1 check("R7 port A before edge", ra_data, 64'h0);
    check("R7 port B before edge", rb_data, 64'h0);
    @(posedge clk);
    #1 wr_en = 1'b0;
    check("R7 port A after edge", ra_data, 64'h55AA33CC0F0F1234);
    check("R7 port B after edge", rb_data, 64'h33CC);

    // R1: reset clears written contents
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    set_a(7'd10, 10'd0, 2'd3); set_b(7'd127, 10'd0, 2'd3);
    #1 check("R1 reg10 after second reset", ra_data, 64'h0);
    check("R1 reg127 after second reset", rb_data, 64'h0);

    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R7 watchdog expired actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule